// File: doc/BRIEF.md
# Gated Integrator Timing Sequencer

This block drives the switch controls of one front-end channel built around a switched gated integrator, whose integration capacitor doubles as the analog sample store. For every bunch-crossing strobe it steps through a fixed sequence. First a short pulse discharges the capacitor. Next comes an integration window covering most of the bunch interval. The hold switch is then opened to freeze the charge, and finally a one-cycle start pulse goes to the downstream 12-bit converter. Since the capacitor itself holds the sample, there is no separate memory-write phase.

The length of each phase is a cycle count taken from a configuration input. A value of zero selects a default that is derived from the clock period, so that capacitor reset plus integration fits inside the 337 ns bunch interval. Two power enables, one for the front end and one for the converter, are raised only during their own slots. A power-pulse input puts the whole channel to sleep. A strobe that arrives while a sequence is under way is dropped and noted in a sticky flag.

The block carries no data stream: every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure. All outputs are decoded combinationally from the state register and gated by the power-pulse enable.

Top module: `gint_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. All six control outputs are low and `overrun` is low.
- R2: A `bx_strobe` sampled high while idle with `pp_en` high starts a sequence. `cap_reset` (together with `pwr_fe`) is high from the next cycle for Lr cycles, where Lr is the effective capacitor-reset length.
- R3: `integrate` (with `pwr_fe`) is high for Li cycles directly after the reset phase. `cap_reset` and `integrate` are never high in the same cycle.
- R4: After integration, `hold` (with `pwr_fe` and `pwr_adc`) is high for Lh cycles. One further cycle follows with `hold`, `adc_start` and `pwr_adc` high and `pwr_fe` low. The block then returns to idle with every output low. One sequence occupies Lr+Li+Lh+1 cycles.
- R5: Each length input of value 0 selects a default: Lr = ceil(RST_NS/CLK_PERIOD_NS), Li = floor(INT_NS/CLK_PERIOD_NS), Lh = ceil(HOLD_NS/CLK_PERIOD_NS), each at least 1. With the default 20 ns period this gives 1, 15 and 1 cycles, and reset plus integration take 320 ns, which is within 337 ns. A nonzero input is used as given.
- R6: A `bx_strobe` sampled high with `pp_en` high while a sequence is running does not change that sequence. It sets `overrun`, which stays high until `rst`.
- R7: While `pp_en` is low, all six control outputs are low in that same cycle. The sequencer returns to idle at the next edge and stays there. Strobes seen in this period start nothing and do not set `overrun`.
- R8: `pwr_fe` is high only in the reset, integrate and hold phases. `pwr_adc` is high only in the hold phase and the convert cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bx_strobe | input | 1 | Bunch-crossing strobe |
| pp_en | input | 1 | Power-pulse enable; low puts the channel to sleep |
| cfg_rst_len | input | CNT_W | Capacitor-reset length in cycles, 0 selects the default |
| cfg_int_len | input | CNT_W | Integration length in cycles, 0 selects the default |
| cfg_hold_len | input | CNT_W | Hold length in cycles before the start pulse, 0 selects the default |
| cap_reset | output | 1 | Fast capacitor discharge switch |
| integrate | output | 1 | Integration window switch |
| hold | output | 1 | Hold switch open, sample frozen |
| adc_start | output | 1 | One-cycle converter start |
| pwr_fe | output | 1 | Front-end power enable |
| pwr_adc | output | 1 | Converter power enable |
| overrun | output | 1 | Sticky flag: strobe arrived while busy |

## Verification
The bench builds the block with CNT_W = 8 and a 20 ns clock, so the zero-coded defaults resolve to 1, 15 and 1 cycles. This makes the full default sequence of 18 cycles short enough to check cycle by cycle. The 8-bit length inputs reach the shortest legal phases (one cycle each) as well as uneven mixes, and these exercise every phase boundary. Directed runs then place a strobe inside a running sequence and drop the power-pulse enable both while idle and mid-integration.

// File: rtl/gis_pkg.sv
package gis_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_INT,
    ST_HOLD,
    ST_CONV
  } gis_state_e;

  localparam int PH_RST  = 0;
  localparam int PH_INT  = 1;
  localparam int PH_HOLD = 2;
  localparam int NUM_PH  = 3;

  // Converts a duration in ns to a cycle count, clamped to [1, max_val].
  function automatic int ns_to_cycles(int ns, int period, bit round_up, int max_val);
    int c;
    c = round_up ? (ns + period - 1) / period : ns / period;
    if (c < 1) c = 1;
    if (c > max_val) c = max_val;
    return c;
  endfunction

endpackage

// File: rtl/gis_len_sel.sv
module gis_len_sel #(
  parameter int CNT_W   = 8,
  parameter int DEF_LEN = 1
) (
  input  logic [CNT_W-1:0] cfg_i,
  output logic [CNT_W-1:0] eff_o
);
  localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_LEN);

  assign eff_o = (cfg_i == '0) ? DEF_V : cfg_i;
endmodule

// File: rtl/gis_phase_timer.sv
module gis_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/gis_fsm.sv
module gis_fsm
  import gis_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic             pp_en_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] len_i [NUM_PH],
  output gis_state_e       state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_len_o,
  output logic             overrun_o
);
  gis_state_e state_q, state_d;
  logic       over_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_len_o = len_i[PH_RST];
    if (!pp_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (strobe_i) begin
          state_d    = ST_RST;
          load_o     = 1'b1;
          load_len_o = len_i[PH_RST];
        end
        ST_RST: if (done_i) begin
          state_d    = ST_INT;
          load_o     = 1'b1;
          load_len_o = len_i[PH_INT];
        end
        ST_INT: if (done_i) begin
          state_d    = ST_HOLD;
          load_o     = 1'b1;
          load_len_o = len_i[PH_HOLD];
        end
        ST_HOLD: if (done_i) state_d = ST_CONV;
        ST_CONV: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      over_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pp_en_i && strobe_i && state_q != ST_IDLE) over_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign overrun_o = over_q;
endmodule

// File: rtl/gis_out_decode.sv
module gis_out_decode
  import gis_pkg::*;
(
  input  gis_state_e state_i,
  input  logic       pp_en_i,
  output logic       cap_reset_o,
  output logic       integrate_o,
  output logic       hold_o,
  output logic       adc_start_o,
  output logic       pwr_fe_o,
  output logic       pwr_adc_o
);
  logic in_rst, in_int, in_hold, in_conv;

  assign in_rst  = (state_i == ST_RST);
  assign in_int  = (state_i == ST_INT);
  assign in_hold = (state_i == ST_HOLD);
  assign in_conv = (state_i == ST_CONV);

  assign cap_reset_o = pp_en_i & in_rst;
  assign integrate_o = pp_en_i & in_int;
  assign hold_o      = pp_en_i & (in_hold | in_conv);
  assign adc_start_o = pp_en_i & in_conv;
  assign pwr_fe_o    = pp_en_i & (in_rst | in_int | in_hold);
  assign pwr_adc_o   = pp_en_i & (in_hold | in_conv);
endmodule

// File: rtl/gint_sequencer.sv
module gint_sequencer
  import gis_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int RST_NS        = 20,
  parameter int INT_NS        = 300,
  parameter int HOLD_NS       = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bx_strobe,
  input  logic             pp_en,
  input  logic [CNT_W-1:0] cfg_rst_len,
  input  logic [CNT_W-1:0] cfg_int_len,
  input  logic [CNT_W-1:0] cfg_hold_len,
  output logic             cap_reset,
  output logic             integrate,
  output logic             hold,
  output logic             adc_start,
  output logic             pwr_fe,
  output logic             pwr_adc,
  output logic             overrun
);
  localparam int MAX_LEN = (1 << CNT_W) - 1;
  localparam int DEF_LEN [NUM_PH] = '{
    ns_to_cycles(RST_NS,  CLK_PERIOD_NS, 1'b1, MAX_LEN),
    ns_to_cycles(INT_NS,  CLK_PERIOD_NS, 1'b0, MAX_LEN),
    ns_to_cycles(HOLD_NS, CLK_PERIOD_NS, 1'b1, MAX_LEN)
  };

  logic [CNT_W-1:0] cfg_len [NUM_PH];
  logic [CNT_W-1:0] eff_len [NUM_PH];
  logic [CNT_W-1:0] load_len;
  logic             load, done;
  gis_state_e       state;

  assign cfg_len[PH_RST]  = cfg_rst_len;
  assign cfg_len[PH_INT]  = cfg_int_len;
  assign cfg_len[PH_HOLD] = cfg_hold_len;

  for (genvar g = 0; g < NUM_PH; g++) begin : g_len
    gis_len_sel #(.CNT_W(CNT_W), .DEF_LEN(DEF_LEN[g])) u_sel (
      .cfg_i (cfg_len[g]),
      .eff_o (eff_len[g])
    );
  end

  gis_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .strobe_i   (bx_strobe),
    .pp_en_i    (pp_en),
    .done_i     (done),
    .len_i      (eff_len),
    .state_o    (state),
    .load_o     (load),
    .load_len_o (load_len),
    .overrun_o  (overrun)
  );

  gis_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .len_i  (load_len),
    .done_o (done)
  );

  gis_out_decode u_dec (
    .state_i     (state),
    .pp_en_i     (pp_en),
    .cap_reset_o (cap_reset),
    .integrate_o (integrate),
    .hold_o      (hold),
    .adc_start_o (adc_start),
    .pwr_fe_o    (pwr_fe),
    .pwr_adc_o   (pwr_adc)
  );
endmodule

// File: rtl/gint_sequencer_chk.sv
module gint_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic bx_strobe,
  input logic pp_en,
  input logic cap_reset,
  input logic integrate,
  input logic hold,
  input logic adc_start,
  input logic pwr_fe,
  input logic pwr_adc,
  input logic overrun
);
  a_r2_start_from_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_reset) |-> $past(bx_strobe) && $past(pp_en));

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(cap_reset && integrate));

  a_r3_int_after_rst: assert property (@(posedge clk) disable iff (rst)
    $rose(integrate) |-> $past(cap_reset));

  a_r4_hold_after_int: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(integrate));

  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  a_r4_start_in_hold: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> hold && pwr_adc && !pwr_fe);

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r7_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
    !pp_en |-> !(cap_reset || integrate || hold || adc_start || pwr_fe || pwr_adc));

  a_r8_fe_power: assert property (@(posedge clk) disable iff (rst)
    (cap_reset || integrate) |-> pwr_fe && !pwr_adc);
endmodule

bind gint_sequencer gint_sequencer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bx_strobe (bx_strobe),
  .pp_en     (pp_en),
  .cap_reset (cap_reset),
  .integrate (integrate),
  .hold      (hold),
  .adc_start (adc_start),
  .pwr_fe    (pwr_fe),
  .pwr_adc   (pwr_adc),
  .overrun   (overrun)
);

// File: tb/gint_sequencer_bench.sv
module gint_sequencer_bench;
  localparam int CNT_W = 8;
  localparam int DEF_R = 1, DEF_I = 15, DEF_H = 1;  // R5: 20/20 up, 300/20 down, 20/20 up
  localparam int NVEC = 6;
  // {cfg_rst, cfg_int, cfg_hold}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd0, 8'd0,  8'd0},
    {8'd1, 8'd1,  8'd1},
    {8'd2, 8'd3,  8'd1},
    {8'd3, 8'd10, 8'd2},
    {8'd5, 8'd2,  8'd4},
    {8'd0, 8'd4,  8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bx_strobe = 1'b0;
  logic pp_en = 1'b1;
  logic [CNT_W-1:0] cfg_rst_len = '0, cfg_int_len = '0, cfg_hold_len = '0;
  logic cap_reset, integrate, hold, adc_start, pwr_fe, pwr_adc, overrun;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gint_sequencer #(.CNT_W(CNT_W)) u_gint_sequencer (
    .clk(clk), .rst(rst), .bx_strobe(bx_strobe), .pp_en(pp_en),
    .cfg_rst_len(cfg_rst_len), .cfg_int_len(cfg_int_len), .cfg_hold_len(cfg_hold_len),
    .cap_reset(cap_reset), .integrate(integrate), .hold(hold), .adc_start(adc_start),
    .pwr_fe(pwr_fe), .pwr_adc(pwr_adc), .overrun(overrun)
  );

  function automatic logic [5:0] outs();
    return {cap_reset, integrate, hold, adc_start, pwr_fe, pwr_adc};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input int cfg, input int def);
    return (cfg == 0) ? def : cfg;
  endfunction

  // Runs one sequence and checks every cycle. mid >= 0 injects a strobe after that cycle.
  task automatic run_seq(input int cr, input int ci, input int ch, input int mid);
    int lr, li, lh, tot;
    logic [5:0] exp;
    string tag;
    lr = eff(cr, DEF_R); li = eff(ci, DEF_I); lh = eff(ch, DEF_H);
    tot = lr + li + lh + 1;
    cfg_rst_len = CNT_W'(cr); cfg_int_len = CNT_W'(ci); cfg_hold_len = CNT_W'(ch);
    bx_strobe = 1'b1;
    @(negedge clk);
    bx_strobe = 1'b0;
    for (int i = 0; i < tot; i++) begin
      if (i < lr) begin exp = 6'b100010; tag = "R2/R5/R8"; end
      else if (i < lr + li) begin exp = 6'b010010; tag = "R3/R5/R8"; end
      else if (i < lr + li + lh) begin exp = 6'b001011; tag = "R4/R5/R8"; end
      else begin exp = 6'b001101; tag = "R4/R8"; end
      chk(outs() == exp, tag, outs(), exp);
      bx_strobe = (i == mid);
      @(negedge clk);
    end
    bx_strobe = 1'b0;
    chk(outs() == 6'b0, "R4 idle after convert", outs(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(outs() == 6'b0, "R1 outputs in reset", outs(), 0);
    chk(overrun == 1'b0, "R1 overrun in reset", overrun, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(outs() == 6'b0, "R1 idle after reset", outs(), 0);

    for (int v = 0; v < NVEC; v++) begin
      run_seq(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), -1);
      @(negedge clk);
    end
    chk(overrun == 1'b0, "R6 no overrun from idle strobes", overrun, 0);

    // R6: strobe while busy, sequence unchanged, flag sticky
    run_seq(2, 4, 2, 3);
    chk(overrun == 1'b1, "R6 overrun set", overrun, 1);
    repeat (4) @(negedge clk);
    chk(overrun == 1'b1, "R6 overrun sticky", overrun, 1);
    chk(outs() == 6'b0, "R6 ignored strobe started nothing", outs(), 0);

    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(overrun == 1'b0, "R1 reset clears overrun", overrun, 0);

    // R7: sleeping, strobes ignored
    pp_en = 1'b0;
    bx_strobe = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(outs() == 6'b0, "R7 sleep outputs low", outs(), 0);
    end
    bx_strobe = 1'b0;
    pp_en = 1'b1;
    @(negedge clk);
    chk(outs() == 6'b0, "R7 no start after wake", outs(), 0);
    chk(overrun == 1'b0, "R7 no overrun while sleeping", overrun, 0);

    // R7: drop mid-integration
    cfg_rst_len = '0; cfg_int_len = '0; cfg_hold_len = '0;
    bx_strobe = 1'b1; @(negedge clk); bx_strobe = 1'b0;
    repeat (3) @(negedge clk);
    chk(integrate == 1'b1, "R3 integrating before drop", integrate, 1);
    pp_en = 1'b0;
    #1;
    chk(outs() == 6'b0, "R7 outputs low same cycle", outs(), 0);
    @(negedge clk);
    pp_en = 1'b1;
    #1;
    chk(outs() == 6'b0, "R7 aborted to idle", outs(), 0);
    repeat (3) @(negedge clk);
    chk(outs() == 6'b0, "R7 stays idle", outs(), 0);

    run_seq(0, 0, 0, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule